// File: doc/BRIEF.md
# Shared DRAM Nibble Access Sequencer

This block times one memory access per eight-cycle period on a DRAM with four data pins. It does this with a one-hot phase ring. In each access the block presents a row address and asserts the row select. It then presents two column addresses in turn, each followed by its own column select. The two four-bit halves that come back are joined into one byte.

At the start of every period the block chooses the owner of the slot. The video fetcher owns it when three conditions hold: the cadence counter is at zero, the timing logic reports that a fetch is permitted, and NMI is low. In every other case the CPU address is used, and the byte is returned as CPU read data when the CPU is reading.

When NMI suppresses a fetch that would otherwise happen, the video address step is still issued, so the screen address keeps moving. The cadence counter lets the video fetch take every period or only every n-th period, which suits screen modes that read fewer bytes per line.

Top module: `dram_slot_sequencer`

## Requirements
- R1: Exactly one of eight phases is active in every cycle. Reset leaves phase 0 active, and the phases advance by one per clock, wrapping from 7 to 0.
- R2: In the cycle after phase 0, `ram_addr` carries bits 14..7 of the address chosen for the period.
- R3: In the cycle after phase 1, `ram_addr` is `{addr[6:0],1'b0}`. In the cycle after phase 4 it is `{addr[6:0],1'b1}`. `ram_addr` does not change in the cycle in which `ram_col_sel` rises.
- R4: `ram_row_sel` is high in the cycles following phases 1 through 6. `ram_col_sel` is high in the cycles following phases 2, 3, 5 and 6. Both are low following phases 7 and 0, and the column select is never high without the row select.
- R5: The slot is video-owned when, in the phase-0 cycle, the cadence count is 0, `fetch_ok` is 1 and `nmi` is 0. Changes to `fetch_ok` or `nmi` after phase 0 do not change the owner of that period.
- R6: The cadence count advances once per period, at phase 7. It returns to 0 after reaching `cad_mod`, so the video fetch can take one period in every `cad_mod+1`. With `cad_mod`=0 every period is eligible.
- R7: `vid_step` pulses for one cycle, in the cycle after phase 6, in every period where the count was 0 and `fetch_ok` was 1. This holds even when `nmi` blocked the fetch.
- R8: In a video-owned period, `vid_valid` pulses for one cycle after phase 6. With the pulse, `vid_byte` holds the nibble sampled at phase 3 in bits 7..4 and the nibble sampled at phase 6 in bits 3..0. The value is held until the next video-owned period.
- R9: In a CPU-owned period with `cpu_rd`=1 sampled at phase 0, `cpu_rdata` is updated after phase 6 in the same nibble order as R8. In every other period `cpu_rdata` keeps its value.
- R10: During reset, `ram_addr`, both selects, `vid_byte`, `vid_valid`, `vid_step` and `cpu_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; eight cycles make one access period |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_addr | input | ADDR_W | Current screen fetch address |
| cpu_addr | input | ADDR_W | CPU address for the slot |
| cpu_rd | input | 1 | CPU is reading in this period |
| nmi | input | 1 | Blocks the video fetch for the period |
| fetch_ok | input | 1 | Timing logic permits a screen fetch |
| cad_mod | input | CAD_W | Cadence modulus minus one |
| ram_din | input | NIB_W | Nibble returned by the DRAM |
| ram_addr | output | RA_W | Multiplexed row/column address |
| ram_row_sel | output | 1 | Row select, active high |
| ram_col_sel | output | 1 | Column select, active high |
| vid_byte | output | 2*NIB_W | Last fetched screen byte |
| vid_valid | output | 1 | One-cycle strobe for a new screen byte |
| vid_step | output | 1 | One-cycle request to advance the screen address |
| cpu_rdata | output | 2*NIB_W | Last byte read for the CPU |

## Verification
A ring that loses or duplicates its token shows at once at the strobe pins: the row and column selects go out of pattern within one period. A cadence counter or owner decision in the wrong state shows up differently. It appears one period later as a missing or extra `vid_valid` pulse, or as a `cpu_rdata` change where none was due. A swapped nibble or a wrong column bit shows only in the assembled byte, seven cycles after the period starts. The bench therefore checks the address and strobes in every cycle of every period, and checks both data outputs at the phase-6 result.

// File: rtl/dss_pkg.sv
package dss_pkg;
    localparam int PHASES    = 8;
    localparam int PH_ROW    = 0;
    localparam int PH_COL0   = 1;
    localparam int PH_STB0   = 2;
    localparam int PH_CAP_HI = 3;
    localparam int PH_COL1   = 4;
    localparam int PH_STB1   = 5;
    localparam int PH_CAP_LO = 6;
    localparam int PH_REL    = 7;

    typedef enum logic [0:0] {
        OWN_CPU = 1'b0,
        OWN_VID = 1'b1
    } owner_e;
endpackage

// File: rtl/dss_phase_ring.sv
module dss_phase_ring #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] phase_oh
);
    localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] ring_d, ring_q;

    always_comb begin
        ring_d = {ring_q[N-2:0], ring_q[N-1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= START;
        else        ring_q <= ring_d;
    end

    assign phase_oh = ring_q;
endmodule

// File: rtl/dss_cadence.sv
module dss_cadence #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] mod_m1,
    output logic         at_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) begin
            if (cnt_q >= mod_m1) cnt_d = '0;
            else                 cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/dss_nibble_join.sv
module dss_nibble_join #(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NIB_W-1:0]   din,
    input  logic               take_hi,
    input  logic               take_lo,
    output logic [2*NIB_W-1:0] byte_out
);
    typedef struct packed {
        logic [NIB_W-1:0]   hi;
        logic [2*NIB_W-1:0] full;
    } join_t;

    join_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_hi) st_d.hi   = din;
        if (take_lo) st_d.full = {st_q.hi, din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_out = st_q.full;
endmodule

// File: rtl/dram_slot_sequencer.sv
module dram_slot_sequencer
    import dss_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RA_W   = 8,
    parameter int NIB_W  = 4,
    parameter int CAD_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   vid_addr,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                nmi,
    input  logic                fetch_ok,
    input  logic [CAD_W-1:0]    cad_mod,
    input  logic [NIB_W-1:0]    ram_din,
    output logic [RA_W-1:0]     ram_addr,
    output logic                ram_row_sel,
    output logic                ram_col_sel,
    output logic [2*NIB_W-1:0]  vid_byte,
    output logic                vid_valid,
    output logic                vid_step,
    output logic [2*NIB_W-1:0]  cpu_rdata
);
    localparam int COL_W  = RA_W - 1;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int N_JOIN = 2;
    localparam int J_VID  = 0;
    localparam int J_CPU  = 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        owner_e            owner;
        logic              would;
        logic              rd;
        logic [RA_W-1:0]   ram_addr;
        logic              row_sel;
        logic              col_sel;
        logic              valid;
        logic              step;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [PHASES-1:0] phase_oh;
    logic              cad_zero;
    logic              want_vid;
    logic [N_JOIN-1:0] take_hi, take_lo;
    logic [BYTE_W-1:0] joined [N_JOIN];

    dss_phase_ring #(.N(PHASES)) ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_oh (phase_oh)
    );

    dss_cadence #(.W(CAD_W)) cad_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (phase_oh[PH_REL]),
        .mod_m1  (cad_mod),
        .at_zero (cad_zero)
    );

    function automatic logic [RA_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[COL_W +: RA_W];
    endfunction

    function automatic logic [RA_W-1:0] col_of(input logic [ADDR_W-1:0] a, input logic lo);
        return {a[COL_W-1:0], lo};
    endfunction

    assign want_vid = cad_zero & fetch_ok;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.valid = 1'b0;
        ctrl_d.step  = 1'b0;
        if (phase_oh[PH_ROW]) begin
            ctrl_d.would    = want_vid;
            ctrl_d.owner    = (want_vid && !nmi) ? OWN_VID : OWN_CPU;
            ctrl_d.rd       = cpu_rd;
            ctrl_d.addr     = (want_vid && !nmi) ? vid_addr : cpu_addr;
            ctrl_d.ram_addr = row_of(ctrl_d.addr);
        end
        if (phase_oh[PH_COL0]) begin
            ctrl_d.row_sel  = 1'b1;
            ctrl_d.ram_addr = col_of(ctrl_q.addr, 1'b0);
        end
        if (phase_oh[PH_STB0]) begin
            ctrl_d.col_sel = 1'b1;
        end
        if (phase_oh[PH_COL1]) begin
            ctrl_d.col_sel  = 1'b0;
            ctrl_d.ram_addr = col_of(ctrl_q.addr, 1'b1);
        end
        if (phase_oh[PH_STB1]) begin
            ctrl_d.col_sel = 1'b1;
        end
        if (phase_oh[PH_CAP_LO]) begin
            ctrl_d.valid = (ctrl_q.owner == OWN_VID);
            ctrl_d.step  = ctrl_q.would;
        end
        if (phase_oh[PH_REL]) begin
            ctrl_d.row_sel = 1'b0;
            ctrl_d.col_sel = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.owner <= OWN_CPU;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        take_hi[J_VID] = phase_oh[PH_CAP_HI] && (ctrl_q.owner == OWN_VID);
        take_lo[J_VID] = phase_oh[PH_CAP_LO] && (ctrl_q.owner == OWN_VID);
        take_hi[J_CPU] = phase_oh[PH_CAP_HI] && (ctrl_q.owner == OWN_CPU) && ctrl_q.rd;
        take_lo[J_CPU] = phase_oh[PH_CAP_LO] && (ctrl_q.owner == OWN_CPU) && ctrl_q.rd;
    end

    for (genvar g = 0; g < N_JOIN; g++) begin : g_join
        dss_nibble_join #(.NIB_W(NIB_W)) join_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (ram_din),
            .take_hi  (take_hi[g]),
            .take_lo  (take_lo[g]),
            .byte_out (joined[g])
        );
    end

    assign ram_addr    = ctrl_q.ram_addr;
    assign ram_row_sel = ctrl_q.row_sel;
    assign ram_col_sel = ctrl_q.col_sel;
    assign vid_valid   = ctrl_q.valid;
    assign vid_step    = ctrl_q.step;
    assign vid_byte    = joined[J_VID];
    assign cpu_rdata   = joined[J_CPU];
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
    parameter int N    = 8,
    parameter int RA_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    phase_oh,
    input logic [RA_W-1:0] ram_addr,
    input logic            ram_row_sel,
    input logic            ram_col_sel,
    input logic            vid_valid,
    input logic            vid_step
);
    // R1
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_oh) == 1);

    // R4
    col_under_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_col_sel |-> ram_row_sel);

    // R4
    idle_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[0] |-> (!ram_row_sel && !ram_col_sel));

    // R3
    col_addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_col_sel) |-> $stable(ram_addr));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |=> !vid_valid);

    // R7
    valid_has_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> vid_step);
endmodule

bind dram_slot_sequencer dss_checker #(
    .N    (dss_pkg::PHASES),
    .RA_W (RA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_oh    (phase_oh),
    .ram_addr    (ram_addr),
    .ram_row_sel (ram_row_sel),
    .ram_col_sel (ram_col_sel),
    .vid_valid   (vid_valid),
    .vid_step    (vid_step)
);

// File: tb/dram_slot_sequencer_tb_top.sv
`timescale 1ns/1ps
module dram_slot_sequencer_tb_top;
    localparam int AW = 16;
    localparam int RW = 8;
    localparam int NW = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] vid_addr = '0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_rd = 1'b0;
    logic          nmi = 1'b0;
    logic          fetch_ok = 1'b0;
    logic [CW-1:0] cad_mod = '0;
    logic [NW-1:0] ram_din;
    logic [RW-1:0] ram_addr;
    logic          ram_row_sel, ram_col_sel;
    logic [7:0]    vid_byte, cpu_rdata;
    logic          vid_valid, vid_step;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dram_slot_sequencer #(.ADDR_W(AW), .RA_W(RW), .NIB_W(NW), .CAD_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .vid_addr(vid_addr), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .nmi(nmi), .fetch_ok(fetch_ok), .cad_mod(cad_mod),
        .ram_din(ram_din), .ram_addr(ram_addr), .ram_row_sel(ram_row_sel),
        .ram_col_sel(ram_col_sel), .vid_byte(vid_byte), .vid_valid(vid_valid),
        .vid_step(vid_step), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [3:0] nib_of(input logic [7:0] r, input logic [7:0] c);
        logic [7:0] t;
        t = (r * 8'd3) ^ (c * 8'd5) ^ (c >> 4) ^ 8'h96;
        return t[3:0] ^ t[7:4];
    endfunction

    function automatic logic [7:0] byte_at(input logic [AW-1:0] a);
        return {nib_of(a[14:7], {a[6:0], 1'b0}), nib_of(a[14:7], {a[6:0], 1'b1})};
    endfunction

    // DRAM model: row latched when the row select rises, data while column select is high
    logic [7:0] row_lat = '0;
    logic [7:0] addr_prev = '0;
    logic       row_prev = 1'b0;
    always @(negedge clk) begin
        if (ram_row_sel && !row_prev) row_lat = addr_prev;
        addr_prev = ram_addr;
        row_prev  = ram_row_sel;
    end
    assign ram_din = ram_col_sel ? nib_of(row_lat, ram_addr) : 4'h0;

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int         cad = 0;
    logic [7:0] exp_vid = '0;
    logic [7:0] exp_cpu = '0;

    task automatic run_period(input logic [AW-1:0] va, input logic [AW-1:0] ca,
                              input logic rd, input logic nm, input logic ok,
                              input logic [CW-1:0] md, input bit flip);
        logic          want, own;
        logic [AW-1:0] a;
        vid_addr = va; cpu_addr = ca; cpu_rd = rd; nmi = nm; fetch_ok = ok; cad_mod = md;
        want = (cad == 0) && ok;
        own  = want && !nm;
        a    = own ? va : ca;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            case (k)
                1: begin
                    check_eq("R2 row address", 16'(ram_addr), 16'(a[14:7]));
                    check_eq("R4 row select idle at phase 0", 16'(ram_row_sel), 16'd0);
                    if (flip) begin fetch_ok = ~ok; nmi = ~nm; end
                end
                2: begin
                    check_eq("R3 first column address", 16'(ram_addr), 16'({a[6:0], 1'b0}));
                    check_eq("R4 row select up", 16'(ram_row_sel), 16'd1);
                    check_eq("R4 column select low before phase 2", 16'(ram_col_sel), 16'd0);
                end
                3: check_eq("R4 first column select", 16'(ram_col_sel), 16'd1);
                5: begin
                    check_eq("R3 second column address", 16'(ram_addr), 16'({a[6:0], 1'b1}));
                    check_eq("R4 column select dropped", 16'(ram_col_sel), 16'd0);
                end
                6: check_eq("R4 second column select", 16'(ram_col_sel), 16'd1);
                7: begin
                    if (own) exp_vid = byte_at(a);
                    else if (rd) exp_cpu = byte_at(ca);
                    check_eq("R5 R8 video valid pulse", 16'(vid_valid), 16'(own));
                    check_eq("R7 video address step", 16'(vid_step), 16'(want));
                    check_eq("R8 video byte", 16'(vid_byte), 16'(exp_vid));
                    check_eq("R9 cpu read data", 16'(cpu_rdata), 16'(exp_cpu));
                end
                8: begin
                    check_eq("R4 selects released", 16'({ram_row_sel, ram_col_sel}), 16'd0);
                    check_eq("R8 valid one cycle", 16'(vid_valid), 16'd0);
                end
                default: ;
            endcase
        end
        cad = (cad >= int'(md)) ? 0 : cad + 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0011);
        repeat (3) @(negedge clk);
        // R10 reset state
        check_eq("R10 reset ram_addr", 16'(ram_addr), 16'd0);
        check_eq("R10 reset selects", 16'({ram_row_sel, ram_col_sel}), 16'd0);
        check_eq("R10 reset strobes", 16'({vid_valid, vid_step}), 16'd0);
        check_eq("R10 reset bytes", {vid_byte, cpu_rdata}, 16'd0);
        rst_n = 1'b1;

        // R5 R8: plain video fetch every period
        run_period(16'h5a37, 16'h1234, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0);
        run_period(16'h7fff, 16'h1234, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0);
        // R9: CPU read when no fetch is permitted
        run_period(16'h3000, 16'h4c81, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
        // R9: CPU not reading leaves cpu_rdata unchanged
        run_period(16'h3000, 16'h0aaa, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        // R7: NMI blocks the fetch but the step still pulses
        run_period(16'h6123, 16'h2b7f, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0);
        // R5: late changes to fetch_ok and nmi are ignored
        run_period(16'h6200, 16'h0080, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
        run_period(16'h6208, 16'h0100, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1);
        // R6: modulus 2, then 4
        for (int i = 0; i < 4; i++)
            run_period(16'h4000 + 16'(i * 8), 16'h0c00 + 16'(i), 1'b1, 1'b0, 1'b1, 2'd1, 1'b0);
        for (int i = 0; i < 8; i++)
            run_period(16'h4800 + 16'(i * 8), 16'h0e00 + 16'(i), 1'b1, 1'b0, 1'b1, 2'd3, 1'b0);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] va, ca;
            logic          rd, nm, ok;
            logic [CW-1:0] md;
            va = 16'($urandom);
            ca = 16'($urandom);
            rd = ($urandom % 4) != 0;
            nm = ($urandom % 5) == 0;
            ok = ($urandom % 3) != 0;
            md = CW'($urandom % 3);
            run_period(va, ca, rd, nm, ok, md, ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule